// File: doc/BRIEF.md
# Asymmetric Serial Clock Divider

This block makes a serial bit clock from the system clock by counting system cycles, so everything stays in one clock domain. A 32-bit scaler register holds two five-bit fields. One field sets how many cycles the output stays high and the other sets how many cycles it stays low. Each phase lasts the field value plus one system cycle, so the duty cycle can be anything from 50/50 to strongly lopsided.

A run enable starts and stops the clock. While stopped, the output sits low. Every start begins with a full high phase. The block also gives one-cycle pulses in the cycle the output rises and in the cycle it falls. Downstream shift logic can use these pulses as enables instead of sampling the divided clock itself. A new scaler value never cuts short the phase already in progress. It is picked up when the next phase begins.

Top module: `asym_clk_div`

## Requirements
- R1: After a start, `clk_out` stays high for exactly H+1 system cycles in every period. H is `wr_data[20:16]` as last written.
- R2: `clk_out` stays low for exactly L+1 cycles in every period, where L is `wr_data[4:0]`. The period is therefore H+L+2 cycles.
- R3: A write with `wr_en` high stores the high field from bits 20:16 and the low field from bits 4:0. From the next cycle on, `rd_data` returns them in the same positions.
- R4: Bits 31:21 and 15:5 of `rd_data` always read zero. Writing ones to those bits has no effect on the divided clock.
- R5: With both fields zero, `clk_out` alternates every system cycle, starting high.
- R6: A write made during a phase leaves that phase's length unchanged. The next phase to start uses the new value.
- R7: With `run` low at a clock edge, `clk_out` is low after that edge. The first edge with `run` high after a stop drives `clk_out` high and starts a full H+1 high phase.
- R8: `rise_pulse` is high for exactly the one cycle in which `clk_out` has just gone from low to high. `fall_pulse` is high for exactly the one cycle in which it has just gone from high to low, and this includes a stop. The two pulses are never high together.
- R9: Reset clears both fields, drives `clk_out` low and clears both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Scaler register write strobe |
| wr_data | input | 32 | Scaler register write value |
| rd_data | output | 32 | Scaler register readback |
| run | input | 1 | Divider run enable |
| clk_out | output | 1 | Divided serial clock |
| rise_pulse | output | 1 | One-cycle marker of a rising output edge |
| fall_pulse | output | 1 | One-cycle marker of a falling output edge |

## Verification
All outputs come from registers, so each result shows up one edge after the stimulus that causes it. A write becomes visible on `rd_data` after the edge that samples `wr_en`. `clk_out` and both pulses change on the edge that samples `run`, and every later phase boundary lands H+1 or L+1 edges after the one before it. The bench drives inputs on the falling edge and samples outputs on the following falling edge. It numbers cycles from the first sample after `run` is raised, and computes the expected level and pulses from the cycle index modulo the period. For a write made mid-phase, it derives the boundary cycles by hand from the edge at which the register updates.

// File: rtl/asym_div_pkg.sv
package asym_div_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  localparam int unsigned DEF_REG_W  = 32;
  localparam int unsigned DEF_FLD_W  = 5;
  localparam int unsigned DEF_HI_LSB = 16;
  localparam int unsigned DEF_LO_LSB = 0;
endpackage

// File: rtl/scaler_reg.sv
module scaler_reg #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned FLD_W  = 5,
  parameter int unsigned HI_LSB = 16,
  parameter int unsigned LO_LSB = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [FLD_W-1:0] hi_o,
  output logic [FLD_W-1:0] lo_o
);
  localparam logic [REG_W-1:0] FLD_ONES = {{(REG_W-FLD_W){1'b0}}, {FLD_W{1'b1}}};
  localparam logic [REG_W-1:0] KEEP_MASK = (FLD_ONES << HI_LSB) | (FLD_ONES << LO_LSB);

  logic [REG_W-1:0] word_q;

  // reserved bits are masked on the way in, so they stay zero
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (wr_en_i) begin
      word_q <= wr_data_i & KEEP_MASK;
    end
  end

  assign rd_data_o = word_q;
  assign hi_o      = word_q[HI_LSB +: FLD_W];
  assign lo_o      = word_q[LO_LSB +: FLD_W];

  AST_WR_HI_FIELD: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> hi_o == $past(wr_data_i[HI_LSB +: FLD_W])); // R3
  AST_WR_LO_FIELD: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> lo_o == $past(wr_data_i[LO_LSB +: FLD_W])); // R3
  AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(rd_data_o)); // R3
endmodule

// File: rtl/phase_gen.sv
module phase_gen
  import asym_div_pkg::*;
#(
  parameter int unsigned FLD_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [FLD_W-1:0] hi_len_i,
  input  logic [FLD_W-1:0] lo_len_i,
  output logic             clk_o,
  output logic             rise_o,
  output logic             fall_o
);
  phase_e           phase_q;
  logic             active_q;
  logic [FLD_W-1:0] cnt_q;
  logic [FLD_W-1:0] len_q;
  logic             rise_q;
  logic             fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_LOW;
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!run_i) begin
        // stopped: park low, mark a fall if one happens here
        fall_q   <= (phase_q == PH_HIGH);
        phase_q  <= PH_LOW;
        active_q <= 1'b0;
        cnt_q    <= '0;
        len_q    <= '0;
      end else if (!active_q) begin
        active_q <= 1'b1;
        phase_q  <= PH_HIGH;
        cnt_q    <= hi_len_i;
        len_q    <= hi_len_i;
        rise_q   <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (phase_q == PH_HIGH) begin
        // phase length sampled only here, at the phase boundary
        phase_q <= PH_LOW;
        cnt_q   <= lo_len_i;
        len_q   <= lo_len_i;
        fall_q  <= 1'b1;
      end else begin
        phase_q <= PH_HIGH;
        cnt_q   <= hi_len_i;
        len_q   <= hi_len_i;
        rise_q  <= 1'b1;
      end
    end
  end

  assign clk_o  = (phase_q == PH_HIGH);
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> clk_o && !$past(clk_o)); // R8
  AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> !clk_o && $past(clk_o)); // R8
  AST_EDGE_MARKED: assert property (@(posedge clk) disable iff (rst)
    (clk_o != $past(clk_o)) |-> (rise_o || fall_o)); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o)); // R8
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !clk_o && cnt_q == '0); // R7
  AST_START_FULL: assert property (@(posedge clk) disable iff (rst)
    (run_i && !active_q) |=> clk_o && rise_o && cnt_q == $past(hi_len_i)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= len_q); // R6
endmodule

// File: rtl/asym_clk_div.sv
module asym_clk_div
  import asym_div_pkg::*;
#(
  parameter int unsigned REG_W  = DEF_REG_W,
  parameter int unsigned FLD_W  = DEF_FLD_W,
  parameter int unsigned HI_LSB = DEF_HI_LSB,
  parameter int unsigned LO_LSB = DEF_LO_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             run,
  output logic             clk_out,
  output logic             rise_pulse,
  output logic             fall_pulse
);
  logic [FLD_W-1:0] hi_len;
  logic [FLD_W-1:0] lo_len;

  scaler_reg #(
    .REG_W (REG_W),
    .FLD_W (FLD_W),
    .HI_LSB(HI_LSB),
    .LO_LSB(LO_LSB)
  ) u_scaler (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .rd_data_o(rd_data),
    .hi_o     (hi_len),
    .lo_o     (lo_len)
  );

  phase_gen #(
    .FLD_W(FLD_W)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .hi_len_i(hi_len),
    .lo_len_i(lo_len),
    .clk_o   (clk_out),
    .rise_o  (rise_pulse),
    .fall_o  (fall_pulse)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> !clk_out && !rise_pulse && !fall_pulse && rd_data == '0); // R9
endmodule

// File: tb/asym_clk_div_tb_top.sv
module asym_clk_div_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        run = 1'b0;
  logic        clk_out;
  logic        rise_pulse;
  logic        fall_pulse;

  int vec_cnt = 0;
  int bad_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  asym_clk_div dut_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .run       (run),
    .clk_out   (clk_out),
    .rise_pulse(rise_pulse),
    .fall_pulse(fall_pulse)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // stop, program (hi,lo), restart, then check three full periods cycle by cycle
  task automatic sweep_one(int hi, int lo);
    int per;
    string rq;
    per = hi + lo + 2;
    rq = (hi == 0 && lo == 0) ? "R5" : "R1/R2";
    @(negedge clk);
    run = 1'b0;
    wr_en = 1'b1;
    wr_data = 32'((hi << 16) | lo);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R3 readback", rd_data, 32'((hi << 16) | lo));
    run = 1'b1;
    for (int i = 0; i < 3 * per; i++) begin
      int p;
      @(negedge clk);
      p = i % per;
      chk(rq, 32'(clk_out), 32'(p <= hi));
      chk("R8 rise", 32'(rise_pulse), 32'(p == 0));
      chk("R8 fall", 32'(fall_pulse), 32'(p == hi + 1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 rd_data", rd_data, 32'h0);
    chk("R9 clk_out", 32'(clk_out), 32'h0);
    chk("R9 rise", 32'(rise_pulse), 32'h0);
    chk("R9 fall", 32'(fall_pulse), 32'h0);
    rst = 1'b0;

    // R4: reserved bits read zero
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 all-ones", rd_data, 32'h001F_001F);
    wr_en = 1'b1;
    wr_data = 32'hFFE0_FFE0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 reserved-only", rd_data, 32'h0);
    run = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R4 R5 toggle", 32'(clk_out), 32'((i % 2) == 0));
    end

    // R1 R2 R5 R8: sweep of small settings plus extremes
    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 4; l++)
        sweep_one(h, l);
    sweep_one(31, 31);
    sweep_one(0, 31);
    sweep_one(31, 0);
    sweep_one(7, 2);

    // R6: write during the high phase of a (2,2) clock
    @(negedge clk);
    run = 1'b0;
    wr_en = 1'b1;
    wr_data = 32'h0002_0002;
    @(negedge clk);
    wr_en = 1'b0;
    run = 1'b1;
    for (int i = 0; i <= 16; i++) begin
      @(negedge clk);
      chk("R6 clk_out", 32'(clk_out), 32'((i <= 2) || (i == 9) || (i == 16)));
      if (i == 1) begin
        wr_en = 1'b1;
        wr_data = 32'h0000_0005;
      end else begin
        wr_en = 1'b0;
      end
    end

    // R7: stop mid-high, then restart with a full high phase (3,3)
    @(negedge clk);
    run = 1'b0;
    wr_en = 1'b1;
    wr_data = 32'h0003_0003;
    @(negedge clk);
    wr_en = 1'b0;
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 running", 32'(clk_out), 32'h1);
    run = 1'b0;
    @(negedge clk);
    chk("R7 stop low", 32'(clk_out), 32'h0);
    chk("R8 stop fall", 32'(fall_pulse), 32'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 held low", 32'(clk_out), 32'h0);
      chk("R8 no pulse", 32'({rise_pulse, fall_pulse}), 32'h0);
    end
    run = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R7 restart", 32'(clk_out), 32'(i < 4));
      chk("R7 restart rise", 32'(rise_pulse), 32'(i == 0));
    end

    // R9: reset while running
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    run = 1'b0;
    chk("R9 mid-run clk_out", 32'(clk_out), 32'h0);
    chk("R9 mid-run rd_data", rd_data, 32'h0);
    chk("R9 mid-run pulses", 32'({rise_pulse, fall_pulse}), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vec_cnt++;
      bad_cnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  end
endmodule